// File: doc/BRIEF.md
# Third-Order Cascaded Accumulator Noise-Shaping Modulator

This block turns an unsigned fractional control word into a short-word signed stream whose long-run average is the word divided by 2^DATA_W. Three first-order accumulators run in cascade. Each one adds its input to its stored value modulo 2^DATA_W and raises a one-bit carry whenever the sum wraps. The first accumulator is fed with the input word. Each later accumulator is fed with the freshly updated stored value of the one before it. A small network of one- and two-sample delays then merges the three carry streams. This network differentiates the second carry once and the third carry twice, so the wrap errors of the first two accumulators cancel. Only the third accumulator's error is left, and it leaves high-pass shaped to third order.

Samples move on valid/ready handshakes. An input sample is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high only while `en` is high and the output register is empty or is being emptied in the same cycle (`out_ready` high). An output sample stays in place, unchanged, for as long as `out_valid` is high and `out_ready` is low. While `en` is low, nothing is accepted and all internal state holds its value. The result for each accepted sample appears in the output register one cycle after it is accepted.

Top module: `mash111_dsm`

## Requirements
- R1: A synchronous active-high `rst` clears all three accumulators and all delay registers. On the first cycle after reset, `out_valid` is 0 and `out_data` is 0.
- R2: Each accumulator computes `acc + x` modulo 2^DATA_W on every accepted sample. Its carry is 1 exactly when the unreduced sum is 2^DATA_W or more.
- R3: Accumulator 1 takes `in_data`. Accumulators 2 and 3 take the updated stored value of the accumulator before them, in the same sample.
- R4: For carries c1, c2, c3 of sample n, the output is c1[n] + c2[n] − c2[n−1] + c3[n] − 2·c3[n−1] + c3[n−2]. Carries from before reset count as 0. The value appears on `out_data` one cycle after sample n is accepted.
- R5: `out_data` is 4-bit two's complement and always lies in −3..+4.
- R6: After reset, 2^DATA_W consecutive accepted samples of a constant k give outputs that sum to a value in k−1..k+2. The mean is therefore k/2^DATA_W.
- R7: `in_ready` = `en` AND (NOT `out_valid` OR `out_ready`). A sample is accepted only when `in_valid` and `in_ready` are both high.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1, `out_data` holds its value, and no input sample is accepted.
- R9: If the output is consumed and no sample is accepted in that cycle, `out_valid` goes to 0 on the next cycle.
- R10: While `en` is 0, no sample is accepted and the accumulators and delays keep their state. After `en` returns high, the output sequence continues exactly as if no pause had occurred.
- R11: A constant input of 0 gives an all-zero output. A constant input of 2^DATA_W−1 stays within range and meets R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; when low, state is frozen and no input is accepted |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take an input sample this cycle |
| in_data | input | DATA_W | Unsigned fractional input word |
| out_valid | output | 1 | Output register holds a sample |
| out_ready | input | 1 | Consumer takes the output sample this cycle |
| out_data | output | 4 | Signed modulator output, −3..+4 |

## Verification
A corrupted accumulator or delay register shows up at `out_data` in the very next accepted sample, as a mismatch against an exact model of the three accumulators and the merge formula. A wrong carry or a wrong feed between stages does the same. A small bias in the first stage may only show as a drift in the output mean, so mean windows of a full 2^DATA_W samples are summed for several constant inputs, including the two extremes. Handshake and enable faults show at once: a sample is dropped, repeated or skipped, and the model comparison on the following samples fails.

// File: rtl/mash_pkg.sv
package mash_pkg;
  localparam int OUT_W  = 4;
  localparam int NSTAGE = 3;
  typedef logic signed [OUT_W-1:0] mash_out_t;
endpackage

// File: rtl/mash_acc_stage.sv
module mash_acc_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] x_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o
);
  logic [W-1:0] acc_q;
  logic [W:0]   full_sum;

  // widened add: top bit is the wrap marker
  assign full_sum = {1'b0, acc_q} + {1'b0, x_i};
  assign sum_o    = full_sum[W-1:0];
  assign carry_o  = full_sum[W];

  always_ff @(posedge clk) begin
    if (rst)      acc_q <= '0;
    else if (adv) acc_q <= full_sum[W-1:0];
  end

  // a wrapped sum is always smaller than the addend, an unwrapped one never is
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    carry_o == (sum_o < x_i));

  p_freeze_r10: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(acc_q));
endmodule

// File: rtl/mash_recomb.sv
module mash_recomb
  import mash_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      adv,
  input  logic      c1_i,
  input  logic      c2_i,
  input  logic      c3_i,
  output mash_out_t y_o
);
  logic c2_d, c3_d, c3_dd;

  always_ff @(posedge clk) begin
    if (rst) begin
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (adv) begin
      c2_d  <= c2_i;
      c3_d  <= c3_i;
      c3_dd <= c3_d;
    end
  end

  // first-stage carry passes straight, second is differenced once,
  // third is differenced twice
  always_comb begin
    y_o = mash_out_t'({3'b000, c1_i})
        + mash_out_t'({3'b000, c2_i}) - mash_out_t'({3'b000, c2_d})
        + mash_out_t'({3'b000, c3_i}) - mash_out_t'({2'b00, c3_d, 1'b0})
        + mash_out_t'({3'b000, c3_dd});
  end

  p_range_r5: assert property (@(posedge clk) disable iff (rst)
    (y_o >= -3) && (y_o <= 4));

  // a negative value can only come from a remembered carry
  p_neg_src_r4: assert property (@(posedge clk) disable iff (rst)
    (y_o < 0) |-> (c2_d || c3_d));
endmodule

// File: rtl/mash111_dsm.sv
module mash111_dsm
  import mash_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic signed [3:0] out_data
);
  logic                adv;
  logic [DATA_W-1:0]   stage_x   [NSTAGE];
  logic [DATA_W-1:0]   stage_sum [NSTAGE];
  logic [NSTAGE-1:0]   carry;
  mash_out_t           y_next;

  assign in_ready = en && (!out_valid || out_ready);
  assign adv      = in_valid && in_ready;

  genvar gi;
  generate
    for (gi = 0; gi < NSTAGE; gi++) begin : g_stage
      if (gi == 0) begin : g_head
        assign stage_x[gi] = in_data;
      end else begin : g_chain
        assign stage_x[gi] = stage_sum[gi-1];
      end
      mash_acc_stage #(.W(DATA_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .adv    (adv),
        .x_i    (stage_x[gi]),
        .sum_o  (stage_sum[gi]),
        .carry_o(carry[gi])
      );
    end
  endgenerate

  mash_recomb u_recomb (
    .clk (clk),
    .rst (rst),
    .adv (adv),
    .c1_i(carry[0]),
    .c2_i(carry[1]),
    .c3_i(carry[2]),
    .y_o (y_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_data  <= y_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == 4'sd0));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_en_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_data));

  p_out_range_r5: assert property (@(posedge clk) disable iff (rst)
    (out_data >= -3) && (out_data <= 4));

  // third stage is fed by the second stage's updated word
  p_last_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    carry[2] == (stage_sum[2] < stage_sum[1]));
endmodule

// File: tb/mash111_dsm_tb_top.sv
`timescale 1ns/1ps
module mash111_dsm_tb_top;
  localparam int NB  = 10;
  localparam int MOD = 1 << NB;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b1;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [NB-1:0]     in_data = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic signed [3:0] out_data;

  int n_chk = 0;
  int n_fail = 0;

  int m_acc [3];
  int m_c2d, m_c3d, m_c3dd;

  always #2.5 clk = ~clk;

  mash111_dsm #(.DATA_W(NB)) dut_i (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 3; i++) m_acc[i] = 0;
    m_c2d = 0; m_c3d = 0; m_c3dd = 0;
  endtask

  // reference built from R2, R3, R4
  function automatic int model_step(input int k);
    int x, s, y;
    int c [3];
    x = k;
    for (int i = 0; i < 3; i++) begin
      s        = m_acc[i] + x;
      c[i]     = (s >= MOD) ? 1 : 0;
      m_acc[i] = s % MOD;
      x        = m_acc[i];
    end
    y = c[0] + c[1] - m_c2d + c[2] - 2 * m_c3d + m_c3dd;
    m_c3dd = m_c3d;
    m_c3d  = c[2];
    m_c2d  = c[1];
    return y;
  endfunction

  // called at a negedge with en=1, out_ready=1; returns at the next negedge
  task automatic step(input int k, input string req, output int y);
    int exp;
    in_valid = 1'b1;
    in_data  = NB'(k);
    exp = model_step(k);
    @(negedge clk);
    y = int'(out_data);
    chk(out_valid == 1'b1, req, int'(out_valid), 1);
    chk(y == exp, req, y, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
    chk(out_data == 4'sd0, "R1 data", int'(out_data), 0);
  endtask

  task automatic t_wrap();
    int y;
    t_reset();
    step(MOD - 1, "R2 first", y);
    chk(y == 0, "R2 no carry", y, 0);
    step(MOD - 1, "R2 second", y);
    chk(y == 3, "R2 all wrap", y, 3);
    for (int i = 0; i < 20; i++) step(MOD - 1 - i, "R2 run", y);
    in_valid = 1'b0;
  endtask

  task automatic t_varied();
    int y;
    int v = 7;
    t_reset();
    for (int i = 0; i < 300; i++) begin
      v = (v * 73 + 41) % MOD;
      step(v, "R3 R4 varied", y);
      chk(y >= -3 && y <= 4, "R5 range", y, 0);
    end
    in_valid = 1'b0;
  endtask

  task automatic t_mean(input int k, input bit zero_chk);
    int y, sum;
    t_reset();
    sum = 0;
    for (int i = 0; i < MOD; i++) begin
      step(k, "R4 mean run", y);
      sum += y;
      if (zero_chk) chk(y == 0, "R11 zero", y, 0);
    end
    in_valid = 1'b0;
    chk(sum >= k - 1 && sum <= k + 2, "R6 mean", sum, k);
  endtask

  task automatic t_handshake_stall();
    int y, y_hold, exp;
    t_reset();
    chk(in_ready == 1'b1, "R7 idle ready", int'(in_ready), 1);
    step(500, "R7 first", y_hold);
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = NB'(611);
    #1;
    chk(in_ready == 1'b0, "R7 blocked", int'(in_ready), 0);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid held", int'(out_valid), 1);
    chk(int'(out_data) == y_hold, "R8 data held", int'(out_data), y_hold);
    out_ready = 1'b1;
    exp = model_step(611);
    @(negedge clk);
    chk(int'(out_data) == exp, "R8 resume", int'(out_data), exp);
    for (int i = 0; i < 10; i++) step(611, "R8 after", y);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 drain", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R7 empty ready", int'(in_ready), 1);
  endtask

  task automatic t_enable();
    int y;
    t_reset();
    for (int i = 0; i < 5; i++) step(389, "R10 before", y);
    en       = 1'b0;
    in_valid = 1'b1;
    in_data  = NB'(389);
    repeat (4) @(negedge clk);
    chk(in_ready == 1'b0, "R10 not ready", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R10 nothing taken", int'(out_valid), 0);
    en = 1'b1;
    for (int i = 0; i < 12; i++) step(389, "R10 after", y);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_wrap();
    t_varied();
    t_mean(0, 1'b1);
    t_mean(MOD - 1, 1'b0);
    t_mean(1, 1'b0);
    t_mean(333, 1'b0);
    t_handshake_stall();
    t_enable();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule